// File: doc/BRIEF.md
# Serial Bus Interrupt-Flag Controller

This block keeps the software-visible event state of a two-wire serial interface. Whenever the protocol engine posts a new status code, the block latches that code. For most codes it also raises an interrupt flag. While the flag is up, the block asks the engine to hold the clock line low, so the bus waits until software has serviced the event. Software acknowledges the event by writing zero to the flag. That write parks the status register on an idle code and releases the clock.

The block also holds a one-shot stop request. When software sets it in slave operation, no STOP is driven onto the wires. Instead, a single-cycle forced-idle pulse tells the engine to behave as though a STOP had arrived and to drop back into the unaddressed receive state. The interrupt request reaching the CPU is gated by a global enable and by a block-level enable.

Top module: `sif_ctl`

## Requirements
- R1: A status update (`st_vld`=1) with a code other than 0xD0 and 0xF8 sets the flag. On the following clock edge the status register holds the new code.
- R2: A status update with code 0xD0 or 0xF8 loads the code into the status register and leaves the flag unchanged.
- R3: A CPU write (`wr_en`=1) with `wr_flag`=1 leaves the flag and the status register unchanged.
- R4: A CPU write with `wr_flag`=0 clears the flag. If the flag was 1, the status register becomes 0xF8 on the same edge. The exception is a status update in the same cycle: its code is loaded instead.
- R5: When a hardware set of the flag and a CPU clear fall in the same cycle, the flag ends up 1.
- R6: `scl_hold` is 1 exactly when the flag is 1 and the status register is not 0xD0.
- R7: `irq` is 1 exactly when the flag, `glob_ie` and `blk_ie` are all 1.
- R8: A CPU write with `wr_stop`=1 while `iface_en`=0 leaves the stop bit and `force_idle` at 0.
- R9: A CPU write with `wr_stop`=1 while `iface_en`=1 sets the stop bit and `force_idle` for exactly one clock. The bit then clears by itself, even if the write is held.
- R10: After reset, the flag, the stop bit, `scl_hold`, `irq` and `force_idle` are 0, and the status register is 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iface_en | input | 1 | Serial interface enable |
| glob_ie | input | 1 | Global interrupt enable |
| blk_ie | input | 1 | Block interrupt enable |
| wr_en | input | 1 | CPU write strobe for the control bits |
| wr_flag | input | 1 | Value written to the interrupt flag (0 clears it) |
| wr_stop | input | 1 | Value written to the stop-request bit |
| st_vld | input | 1 | Status code update from the protocol engine |
| st_code | input | 8 | New status code |
| status | output | 8 | Current status register |
| flag | output | 1 | Interrupt flag readback |
| stop_bit | output | 1 | Stop-request bit readback |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Request to hold the clock line low |
| force_idle | output | 1 | One-cycle pulse that returns the engine to unaddressed idle |

## Verification
A flag stuck high or stuck low shows up on `scl_hold`, `irq` and the flag readback on the first edge after the status update or clearing write that should have moved it. A status register that fails to load, or loads the wrong value, is visible on `status` the very next cycle. It also changes `scl_hold` whenever the code involved is the one that exempts clock stretching. A stop bit that lingers or ignores its enable shows as a `force_idle` pulse that is too long or appears where none should, one cycle after the write.

// File: rtl/sif_pkg.sv
package sif_pkg;
    localparam int unsigned SIF_ST_W = 8;
    localparam logic [SIF_ST_W-1:0] SIF_IDLE_CODE  = 8'hF8;
    localparam logic [SIF_ST_W-1:0] SIF_QUIET_CODE = 8'hD0;

    typedef struct packed {
        logic en;
        logic flag_val;
        logic stop_val;
    } cpu_wr_t;
endpackage

// File: rtl/sif_flag_unit.sv
module sif_flag_unit
    import sif_pkg::*;
#(
    parameter int unsigned         ST_W  = SIF_ST_W,
    parameter logic [ST_W-1:0]     IDLE  = SIF_IDLE_CODE,
    parameter logic [ST_W-1:0]     QUIET = SIF_QUIET_CODE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cpu_wr_t         wr,
    input  logic            st_vld,
    input  logic [ST_W-1:0] st_code,
    output logic            flag_o,
    output logic [ST_W-1:0] status_o,
    output logic            hold_o
);
    typedef struct packed {
        logic            flag;
        logic [ST_W-1:0] status;
    } fstate_t;

    fstate_t s_d, s_q;
    logic    hw_set;
    logic    sw_clr;

    always_comb begin
        hw_set = st_vld && (st_code != QUIET) && (st_code != IDLE);
        sw_clr = wr.en && !wr.flag_val;
        s_d    = s_q;
        if (hw_set) begin
            s_d.flag = 1'b1;
        end else if (sw_clr) begin
            s_d.flag = 1'b0;
        end
        if (st_vld) begin
            s_d.status = st_code;
        end else if (sw_clr && s_q.flag) begin
            s_d.status = IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.flag   <= 1'b0;
            s_q.status <= IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag_o   = s_q.flag;
    assign status_o = s_q.status;
    assign hold_o   = s_q.flag && (s_q.status != QUIET);

    AST_HW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_vld && st_code != QUIET && st_code != IDLE) |=> (flag_o && status_o == $past(st_code))); // R1
    AST_QUIET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_vld && (st_code == QUIET || st_code == IDLE) && !(wr.en && !wr.flag_val)) |=> (flag_o == $past(flag_o))); // R2
    AST_W1_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.en && wr.flag_val && !st_vld) |=> ($stable(flag_o) && $stable(status_o))); // R3
    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && wr.en && !wr.flag_val && !st_vld) |=> (!flag_o && status_o == IDLE)); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_vld && st_code != QUIET && st_code != IDLE && wr.en && !wr.flag_val) |=> flag_o); // R5
endmodule

// File: rtl/sif_stop_unit.sv
module sif_stop_unit
    import sif_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    iface_en,
    input  cpu_wr_t wr,
    output logic    stop_o
);
    typedef struct packed {
        logic stop;
    } sstate_t;

    sstate_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.stop = wr.en && wr.stop_val && iface_en && !s_q.stop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.stop <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stop_o = s_q.stop;

    AST_STOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !iface_en |=> !stop_o); // R8
    AST_STOP_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o); // R9
    AST_STOP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.en && wr.stop_val && iface_en && !stop_o) |=> stop_o); // R9
endmodule

// File: rtl/sif_ctl.sv
module sif_ctl
    import sif_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                iface_en,
    input  logic                glob_ie,
    input  logic                blk_ie,
    input  logic                wr_en,
    input  logic                wr_flag,
    input  logic                wr_stop,
    input  logic                st_vld,
    input  logic [SIF_ST_W-1:0] st_code,
    output logic [SIF_ST_W-1:0] status,
    output logic                flag,
    output logic                stop_bit,
    output logic                irq,
    output logic                scl_hold,
    output logic                force_idle
);
    cpu_wr_t wr_cmd;

    always_comb begin
        wr_cmd.en       = wr_en;
        wr_cmd.flag_val = wr_flag;
        wr_cmd.stop_val = wr_stop;
    end

    sif_flag_unit #(
        .ST_W  (SIF_ST_W),
        .IDLE  (SIF_IDLE_CODE),
        .QUIET (SIF_QUIET_CODE)
    ) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_cmd),
        .st_vld   (st_vld),
        .st_code  (st_code),
        .flag_o   (flag),
        .status_o (status),
        .hold_o   (scl_hold)
    );

    sif_stop_unit u_stop (
        .clk      (clk),
        .rst_n    (rst_n),
        .iface_en (iface_en),
        .wr       (wr_cmd),
        .stop_o   (stop_bit)
    );

    assign force_idle = stop_bit;
    assign irq        = flag && glob_ie && blk_ie;

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (status == SIF_QUIET_CODE) |-> !scl_hold); // R6
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (scl_hold || status == SIF_QUIET_CODE)); // R7
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> (!irq && !scl_hold)); // R7
endmodule

// File: tb/tb_sif_ctl.sv
module tb_sif_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iface_en = 1'b0, glob_ie = 1'b0, blk_ie = 1'b0;
    logic       wr_en = 1'b0, wr_flag = 1'b0, wr_stop = 1'b0;
    logic       st_vld = 1'b0;
    logic [7:0] st_code = 8'h00;
    logic [7:0] status;
    logic       flag, stop_bit, irq, scl_hold, force_idle;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sif_ctl dut (
        .clk(clk), .rst_n(rst_n), .iface_en(iface_en), .glob_ie(glob_ie),
        .blk_ie(blk_ie), .wr_en(wr_en), .wr_flag(wr_flag), .wr_stop(wr_stop),
        .st_vld(st_vld), .st_code(st_code), .status(status), .flag(flag),
        .stop_bit(stop_bit), .irq(irq), .scl_hold(scl_hold), .force_idle(force_idle)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic post(input logic [7:0] code);
        st_vld = 1'b1; st_code = code;
        @(negedge clk);
        st_vld = 1'b0;
    endtask

    task automatic cpu_wr(input logic fv, input logic sv);
        wr_en = 1'b1; wr_flag = fv; wr_stop = sv;
        @(negedge clk);
        wr_en = 1'b0; wr_flag = 1'b0; wr_stop = 1'b0;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 flag", flag, 0);
        check("R10 status", status, 8'hF8);
        check("R10 stop", stop_bit, 0);
        check("R10 hold", scl_hold, 0);
        check("R10 force_idle", force_idle, 0);
        rst_n = 1'b1;
        glob_ie = 1'b1; blk_ie = 1'b1;
        @(negedge clk);
        check("R10 irq", irq, 0);

        for (int c = 0; c < 256; c++) begin
            bit exp_set;
            exp_set = (c != 8'hD0) && (c != 8'hF8);
            post(c[7:0]);
            check("R1/R2 flag", flag, exp_set);
            check("R1 status", status, c);
            check("R6 hold", scl_hold, exp_set);
            check("R7 irq", irq, exp_set);
            cpu_wr(1'b1, 1'b0);
            check("R3 flag", flag, exp_set);
            check("R3 status", status, c);
            cpu_wr(1'b0, 1'b0);
            check("R4 flag", flag, 0);
            check("R4 status", status, exp_set ? 8'hF8 : c);
            check("R6 hold off", scl_hold, 0);
        end

        // R2 and R6: quiet code while the flag is up
        post(8'h10);
        post(8'hD0);
        check("R2 flag kept", flag, 1);
        check("R6 quiet no hold", scl_hold, 0);
        post(8'hF8);
        check("R2 flag kept F8", flag, 1);
        check("R6 hold at F8", scl_hold, 1);

        // R7: every enable combination
        for (int m = 0; m < 4; m++) begin
            glob_ie = m[0]; blk_ie = m[1];
            #1;
            check("R7 gating", irq, (m == 3) ? 1 : 0);
        end
        glob_ie = 1'b1; blk_ie = 1'b1;

        // R5: set and clear in the same cycle
        cpu_wr(1'b0, 1'b0);
        st_vld = 1'b1; st_code = 8'h20; wr_en = 1'b1; wr_flag = 1'b0;
        @(negedge clk);
        st_vld = 1'b0; wr_en = 1'b0;
        check("R5 set wins", flag, 1);
        check("R5 status", status, 8'h20);

        // R4: clear concurrent with a quiet update keeps the update code
        st_vld = 1'b1; st_code = 8'hD0; wr_en = 1'b1; wr_flag = 1'b0;
        @(negedge clk);
        st_vld = 1'b0; wr_en = 1'b0;
        check("R4 clr flag", flag, 0);
        check("R4 update wins", status, 8'hD0);

        // R8: stop blocked while disabled
        iface_en = 1'b0;
        cpu_wr(1'b1, 1'b1);
        check("R8 stop", stop_bit, 0);
        check("R8 force_idle", force_idle, 0);

        // R9: one-shot stop, including a held write
        iface_en = 1'b1;
        cpu_wr(1'b1, 1'b1);
        check("R9 stop set", stop_bit, 1);
        check("R9 force_idle", force_idle, 1);
        @(negedge clk);
        check("R9 self clear", stop_bit, 0);
        wr_en = 1'b1; wr_flag = 1'b1; wr_stop = 1'b1;
        @(negedge clk);
        check("R9 held 1st", force_idle, 1);
        @(negedge clk);
        check("R9 held 2nd", force_idle, 0);
        wr_en = 1'b0; wr_stop = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule